// File: doc/BRIEF.md
# SIMD Widening Alternate-Lane Add/Subtract Unit

This unit performs widening vector addition and subtraction on alternate lanes. It takes two source vectors of up to 256 bits and splits them into narrow elements of 8, 16, 32 or 64 bits. For each pair of adjacent elements it takes either the lower-indexed (even) member or the higher-indexed (odd) member from both sources. It extends both chosen values to twice their width and adds or subtracts them. Each result fills one double-width lane of the output, so 64-bit sources give 128-bit result lanes.

There are three extension modes. Signed mode sign-extends both operands. Unsigned mode zero-extends both. Mixed mode zero-extends the first operand and sign-extends the second, and allows only addition. The operation runs on either a 128-bit or a 256-bit vector. The result is registered one clock after a valid input, together with an output strobe and a flag that marks an undefined request.

Top module: `vwide_addsub`

## Requirements
- R1: Result lane i reads source element 2i of both vectors when `sel_odd` is 0, and element 2i+1 when `sel_odd` is 1. Element k of width s occupies bits [k*s+s-1 : k*s].
- R2: `elem_size` selects the source width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. The result lane is twice the source width. `op_sub`=0 adds and 1 subtracts (A minus B). Each lane result wraps modulo 2 to the power of the lane width.
- R3: With `sign_mode`=0 (signed), both selected elements are sign-extended before the operation.
- R4: With `sign_mode`=1 (unsigned), both selected elements are zero-extended. An unsigned difference below zero gives the wrapped bit pattern and raises no flag.
- R5: With `sign_mode`=2 (mixed) and `op_sub`=0, the element from A is zero-extended, the element from B is sign-extended, and the two are added.
- R6: With `sign_mode`=2 and `op_sub`=1, or with `sign_mode`=3 (reserved), the accepted request sets `out_illegal` to 1 and makes `out_data` all zero. Any other accepted request sets `out_illegal` to 0.
- R7: With `long_vec`=0 (128-bit form), the unit produces 16 / (result bytes) lanes, and bits 255:128 of `out_data` are zero.
- R8: With `long_vec`=1 (256-bit form), the unit produces 32 / (result bytes) lanes. With 64-bit sources this means two 128-bit lanes, taken from doublewords 0 and 2 (even) or from doublewords 1 and 3 (odd).
- R9: `out_valid` equals `in_valid` delayed by one clock. `out_data` and `out_illegal` show the result of the request accepted on the previous edge. Synchronous active-high `rst` clears `out_valid`, `out_data` and `out_illegal`.
- R10: While `in_valid` is 0, `out_data` and `out_illegal` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 256 | First source vector (A) |
| src_b | input | 256 | Second source vector (B) |
| op_sub | input | 1 | 0 add, 1 subtract A minus B |
| sel_odd | input | 1 | 0 even elements, 1 odd elements |
| elem_size | input | 2 | Source element width code |
| sign_mode | input | 2 | 0 signed, 1 unsigned, 2 mixed, 3 reserved |
| long_vec | input | 1 | 0 selects 128 bits, 1 selects 256 bits |
| out_valid | output | 1 | Result strobe |
| out_data | output | 256 | Result vector |
| out_illegal | output | 1 | Undefined combination flag |

## Verification
The assertions assume that `rst` is held for at least one edge before any request, and that every input is at a known level at each clock edge. They take no other assumption about the inputs: any mix of width, mode, length and strobe is allowed, including the reserved mode and mixed subtraction. The stimulus therefore holds reset at the start and always drives known values. It draws every control field over its full range, the reserved codes included. It also changes the data and control inputs during idle cycles, so that the hold properties are exercised against inputs that do not stay still.

// File: rtl/vwide_pkg.sv
package vwide_pkg;

  typedef enum logic [1:0] {
    MD_SIGNED   = 2'd0,
    MD_UNSIGNED = 2'd1,
    MD_MIXED    = 2'd2,
    MD_RESERVED = 2'd3
  } ext_mode_e;

  // First source operand is sign-extended only in fully signed mode.
  function automatic logic a_is_signed(input logic [1:0] mode);
    return mode == MD_SIGNED;
  endfunction

  // Second source operand is sign-extended in signed and mixed modes.
  function automatic logic b_is_signed(input logic [1:0] mode);
    return (mode == MD_SIGNED) || (mode == MD_MIXED);
  endfunction

  // Combinations with no defined result.
  function automatic logic combo_undefined(input logic [1:0] mode, input logic sub);
    return (mode == MD_RESERVED) || ((mode == MD_MIXED) && sub);
  endfunction

endpackage

// File: rtl/vwide_lane.sv
module vwide_lane #(
  parameter int SW = 8
) (
  input  logic [2*SW-1:0] a_pair,
  input  logic [2*SW-1:0] b_pair,
  input  logic            pick_hi,
  input  logic            do_sub,
  input  logic            a_sx,
  input  logic            b_sx,
  output logic [2*SW-1:0] res
);
  localparam int DW = 2 * SW;

  function automatic logic [DW-1:0] widen(input logic [SW-1:0] v, input logic sx);
    return {{SW{sx & v[SW-1]}}, v};
  endfunction

  logic [SW-1:0] a_el, b_el;
  logic [DW-1:0] a_w, b_w;

  always_comb begin
    a_el = pick_hi ? a_pair[DW-1:SW] : a_pair[SW-1:0];
    b_el = pick_hi ? b_pair[DW-1:SW] : b_pair[SW-1:0];
    a_w  = widen(a_el, a_sx);
    b_w  = widen(b_el, b_sx);
    res  = do_sub ? (a_w - b_w) : (a_w + b_w);
  end
endmodule

// File: rtl/vwide_slice.sv
module vwide_slice #(
  parameter int SW   = 8,
  parameter int VLEN = 256
) (
  input  logic [VLEN-1:0] va,
  input  logic [VLEN-1:0] vb,
  input  logic            pick_hi,
  input  logic            do_sub,
  input  logic            a_sx,
  input  logic            b_sx,
  output logic [VLEN-1:0] vres
);
  localparam int DW    = 2 * SW;
  localparam int LANES = VLEN / DW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vwide_lane #(.SW(SW)) u_lane (
      .a_pair (va[i*DW +: DW]),
      .b_pair (vb[i*DW +: DW]),
      .pick_hi(pick_hi),
      .do_sub (do_sub),
      .a_sx   (a_sx),
      .b_sx   (b_sx),
      .res    (vres[i*DW +: DW])
    );
  end
endmodule

// File: rtl/vwide_addsub.sv
module vwide_addsub
  import vwide_pkg::*;
#(
  parameter int VLEN   = 256,
  parameter int BASE_W = 8,
  parameter int NSIZE  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic            op_sub,
  input  logic            sel_odd,
  input  logic [1:0]      elem_size,
  input  logic [1:0]      sign_mode,
  input  logic            long_vec,
  output logic            out_valid,
  output logic [VLEN-1:0] out_data,
  output logic            out_illegal
);
  localparam int HALF_V = VLEN / 2;

  logic            a_sx, b_sx;
  logic            evt_illegal;
  logic            evt_short;
  logic [VLEN-1:0] slice_res [NSIZE];
  logic [VLEN-1:0] sel_res;
  logic [VLEN-1:0] shaped;

  assign a_sx        = a_is_signed(sign_mode);
  assign b_sx        = b_is_signed(sign_mode);
  assign evt_illegal = combo_undefined(sign_mode, op_sub);
  assign evt_short   = ~long_vec;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    vwide_slice #(.SW(BASE_W << g), .VLEN(VLEN)) u_slice (
      .va     (src_a),
      .vb     (src_b),
      .pick_hi(sel_odd),
      .do_sub (op_sub),
      .a_sx   (a_sx),
      .b_sx   (b_sx),
      .vres   (slice_res[g])
    );
  end

  always_comb begin
    sel_res = slice_res[elem_size];
    shaped  = sel_res;
    if (evt_short) shaped[VLEN-1:HALF_V] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= evt_illegal;
        out_data    <= evt_illegal ? '0 : shaped;
      end
    end
  end
endmodule

// File: rtl/vwide_addsub_chk.sv
module vwide_addsub_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            long_vec,
  input logic            op_sub,
  input logic [1:0]      sign_mode,
  input logic            evt_illegal,
  input logic            evt_short,
  input logic            out_valid,
  input logic [VLEN-1:0] out_data,
  input logic            out_illegal
);
  localparam int HALF_V = VLEN / 2;

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r6_mixed_sub_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sign_mode == 2'd2 && op_sub) |=> (out_illegal && out_data == '0));
  a_r6_reserved_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sign_mode == 2'd3) |=> out_illegal);
  a_r6_legal_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !evt_illegal) |=> !out_illegal);
  a_r7_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && evt_short) |=> (out_data[VLEN-1:HALF_V] == '0));
  a_r7_short_decode: assert property (@(posedge clk) disable iff (rst)
    evt_short |-> !long_vec);
  a_r10_hold_data: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));
endmodule

bind vwide_addsub vwide_addsub_chk #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .long_vec   (long_vec),
  .op_sub     (op_sub),
  .sign_mode  (sign_mode),
  .evt_illegal(evt_illegal),
  .evt_short  (evt_short),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_illegal(out_illegal)
);

// File: tb/sim_vwide_addsub.sv
`timescale 1ns/1ps
module sim_vwide_addsub;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [255:0] src_a = '0, src_b = '0;
  logic         op_sub = 1'b0, sel_odd = 1'b0, long_vec = 1'b0;
  logic [1:0]   elem_size = 2'd0, sign_mode = 2'd0;
  logic         out_valid, out_illegal;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R9";

  always #2.5 clk = ~clk;

  vwide_addsub u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .op_sub(op_sub), .sel_odd(sel_odd), .elem_size(elem_size),
    .sign_mode(sign_mode), .long_vec(long_vec), .out_valid(out_valid),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  // Behavioural reference: numeric extension in a wide integer, then truncate.
  function automatic logic [255:0] ref_calc(input logic [255:0] a, input logic [255:0] b,
      input bit sub, input bit odd, input int sz, input int md, input bit lng);
    int sw = 8 << sz;
    int lanes = (lng ? 32 : 16) / (sw / 4);
    logic [255:0] r = '0;
    if (md == 3 || (md == 2 && sub)) return '0;
    for (int i = 0; i < lanes; i++) begin
      int k = 2 * i + (odd ? 1 : 0);
      logic [130:0] ea, eb, s, m;
      ea = 131'((a >> (k * sw)) & ((256'd1 << sw) - 1));
      eb = 131'((b >> (k * sw)) & ((256'd1 << sw) - 1));
      if (md == 0 && ea[sw-1]) ea = ea - (131'd1 << sw);
      if ((md == 0 || md == 2) && eb[sw-1]) eb = eb - (131'd1 << sw);
      s = sub ? ea - eb : ea + eb;
      m = (131'd1 << (2 * sw)) - 1;
      r = r | (256'(s & m) << (i * 2 * sw));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock model, updated at the edge from stable inputs.
  logic         e_valid = 0, e_ill = 0, armed = 0;
  logic [255:0] e_data = '0;
  string        e_tag = "R9";
  always @(posedge clk) begin
    armed <= 1;
    e_tag <= cur_tag;
    if (rst) begin
      e_valid <= 0; e_data <= '0; e_ill <= 0;
    end else begin
      e_valid <= in_valid;
      if (in_valid) begin
        e_ill  <= (sign_mode == 3) || (sign_mode == 2 && op_sub);
        e_data <= ref_calc(src_a, src_b, op_sub, sel_odd, elem_size, sign_mode, long_vec);
      end
    end
  end
  always @(negedge clk) begin
    if (armed && !finished) begin
      check({e_tag, " valid (R9)"}, 256'(out_valid), 256'(e_valid));
      check({e_tag, " data"}, out_data, e_data);
      check({e_tag, " flag (R6)"}, 256'(out_illegal), 256'(e_ill));
    end
  end

  task automatic issue(input logic [255:0] a, input logic [255:0] b, input bit sub, input bit odd,
      input int sz, input int md, input bit lng, input string tag);
    cur_tag = tag;
    in_valid = 1; src_a = a; src_b = b; op_sub = sub; sel_odd = odd;
    elem_size = 2'(sz); sign_mode = 2'(md); long_vec = lng;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cur_tag = tag;
    in_valid = 0;
    src_a = {8{$urandom}}; src_b = {8{$urandom}};
    op_sub = 1'($urandom); sel_odd = 1'($urandom); long_vec = 1'($urandom);
    elem_size = 2'($urandom); sign_mode = 2'($urandom);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset valid", 256'(out_valid), 256'd0);
    check("R9 reset data", out_data, '0);
    check("R9 reset flag", 256'(out_illegal), 256'd0);
    rst = 0;

    // R3: signed byte 0x80 + 0x80 = -256
    issue(256'h80, 256'h80, 0, 0, 0, 0, 0, "R3");
    check("R3 signed byte add", 256'(out_data[15:0]), 256'hFF00);
    // R4: unsigned 0 - 1 wraps
    issue(256'h00, 256'h01, 1, 0, 0, 1, 0, "R4");
    check("R4 unsigned wrap", 256'(out_data[15:0]), 256'hFFFF);
    // R1: odd element picked
    issue(256'h0570, 256'h0390, 0, 1, 0, 1, 0, "R1");
    check("R1 odd select", 256'(out_data[15:0]), 256'h0008);
    issue(256'h0570, 256'h0390, 0, 0, 0, 1, 0, "R1");
    check("R1 even select", 256'(out_data[15:0]), 256'h0100);
    // R5: mixed 0xFFFF(65535) + 0xFFFF(-1)
    issue(256'hFFFF, 256'hFFFF, 0, 0, 1, 2, 0, "R5");
    check("R5 mixed add", 256'(out_data[31:0]), 256'h0000FFFE);
    // R8: 64-bit odd, long form, two 128-bit lanes
    issue({64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd5, 64'd0},
          {64'd1, 64'd0, 64'd7, 64'd0}, 0, 1, 3, 0, 1, "R8");
    check("R8 lane1", 256'(out_data[255:128]), 256'd0);
    check("R8 lane0", 256'(out_data[127:0]), 256'd12);
    // R7: short form clears the upper half
    issue({256{1'b1}}, {256{1'b1}}, 0, 0, 0, 1, 0, "R7");
    check("R7 upper zero", 256'(out_data[255:128]), 256'd0);
    check("R7 lane pattern", 256'(out_data[127:0]), {128'd0, {8{16'h01FE}}});
    // R6: undefined combinations
    issue({256{1'b1}}, 256'd3, 1, 0, 1, 2, 1, "R6");
    check("R6 mixed sub data", out_data, '0);
    check("R6 mixed sub flag", 256'(out_illegal), 256'd1);
    issue({256{1'b1}}, 256'd3, 0, 1, 2, 3, 1, "R6");
    check("R6 reserved flag", 256'(out_illegal), 256'd1);
    // R10: hold through idle cycles with moving inputs
    issue({8{32'h1234_5678}}, {8{32'h0F0F_0F0F}}, 1, 0, 2, 0, 1, "R2");
    held = out_data;
    repeat (5) idle("R10");
    check("R10 hold data", out_data, held);
    check("R10 hold flag", 256'(out_illegal), 256'd0);

    // R2: all widths and modes, mixed with idle cycles
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 4) == 0) idle("R10");
      else issue({8{$urandom}}, {8{$urandom}}, 1'($urandom), 1'($urandom),
                 $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), "R2");
    end
    idle("R9");
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule